// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Router

This block gathers level-sensitive interrupt lines from up to 64 devices into one shared raw request register. Each of four CPUs owns a 64-bit enable mask. A CPU's hardware interrupt output is high whenever at least one raw request is also enabled in that CPU's mask. Software writes the masks through a simple 64-bit register port. Through the same port it can read the raw requests, each mask, and, for each CPU, a read-only view of the requests that survive its mask.

One request bit is reserved for the cascaded legacy interrupt controller. That bit comes from a dedicated input and not from the device vector. Every register access is a full 64-bit word, and data bit 0 is the least significant bit. Outputs are registered: a change on a request line or a mask write shows up on the CPU outputs after one clock edge.

Top module: `irq_router`

## Requirements
- R1: Raw request bit i follows the level of `dev_req[i]`, sampled on each rising clock edge: set while the line is high, clear while it is low. Bit 55 instead follows `legacy_req`, and `dev_req[55]` has no effect.
- R2: `cpu_irq[n]` is high exactly when (mask of CPU n AND raw requests) is nonzero. It is updated on the same edge that captures a request change.
- R3: A write to offset 0x200 (CPU0), 0x240 (CPU1), 0x600 (CPU2) or 0x640 (CPU3) stores all 64 data bits as that CPU's mask. On the same edge, the CPU's output is recomputed from the new mask and the current requests.
- R4: A mask write changes only the addressed CPU's mask and output. The other masks keep their values.
- R5: A read of a mask offset returns the stored mask.
- R6: A read of offset 0x280 (CPU0), 0x2C0 (CPU1), 0x680 (CPU2) or 0x6C0 (CPU3) returns that CPU's mask AND the raw requests.
- R7: A read of offset 0x300 returns the raw request register.
- R8: Writes to 0x300 and to the masked-request offsets change no state and raise no error.
- R9: Any other offset, including a misaligned one, is unassigned. A read there returns all ones. A read or write there pulses `reg_err` for one cycle, and an unassigned write changes nothing.
- R10: During and after reset, every mask and the raw register are zero, all CPU outputs are low, `reg_rdata` is zero and `reg_err` is low.
- R11: Read data appears in the cycle after `reg_rd_en` is sampled high. It holds until the next read, and `reg_err` is low when no access was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 64 | Device interrupt levels, bit i per device |
| legacy_req | input | 1 | Level from the cascaded legacy controller, lands on request bit 55 |
| reg_wr_en | input | 1 | Register write strobe, one word per cycle |
| reg_rd_en | input | 1 | Register read strobe, one word per cycle |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered and held |
| reg_err | output | 1 | One-cycle pulse after an access to an unassigned offset |
| cpu_irq | output | 4 | Hardware interrupt request per CPU |

## Verification
The assertions assume that the device and legacy lines and both strobes carry known values from the first clock onwards. They also assume that a mask write and a read never target different registers in the same cycle in a way the checks would need to tell apart. The bench drives every input from time zero, changes inputs only on falling edges, and issues one access at a time. The properties about a single offset (zeroing CPU0's mask, the unassigned read at 0xFF8, the write to the raw register) therefore see clean, isolated strobes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ADDR_W    = 12;
    localparam int MAX_CPU   = 4;
    localparam int CPU_IDX_W = 2;

    localparam logic [ADDR_W-1:0] OFS_RAW        = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_LOW_GROUP  = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_HIGH_GROUP = 12'h600;
    localparam logic [ADDR_W-1:0] OFS_STRIDE     = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_VIEW_SKEW  = 12'h080;

    typedef enum logic [1:0] {
        ACC_RAW,
        ACC_MASK,
        ACC_VIEW,
        ACC_BAD
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e              kind;
        logic [CPU_IDX_W-1:0]   cpu;
    } acc_decode_t;

    // CPUs come in pairs; each pair sits in its own 0x40-strided group.
    function automatic logic [ADDR_W-1:0] mask_ofs(input int unsigned n);
        logic [ADDR_W-1:0] base;
        base = (n < 2) ? OFS_LOW_GROUP : OFS_HIGH_GROUP;
        return base + (ADDR_W'(n % 2) * OFS_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] view_ofs(input int unsigned n);
        return mask_ofs(n) + OFS_VIEW_SKEW;
    endfunction

    function automatic acc_decode_t decode_ofs(input logic [ADDR_W-1:0] a,
                                               input int unsigned       ncpu);
        acc_decode_t r;
        r.kind = ACC_BAD;
        r.cpu  = '0;
        if (a == OFS_RAW) begin
            r.kind = ACC_RAW;
        end
        for (int unsigned n = 0; n < ncpu; n++) begin
            if (a == mask_ofs(n)) begin
                r.kind = ACC_MASK;
                r.cpu  = CPU_IDX_W'(n);
            end
            if (a == view_ofs(n)) begin
                r.kind = ACC_VIEW;
                r.cpu  = CPU_IDX_W'(n);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
    parameter int DATA_W     = 64,
    parameter int LEGACY_BIT = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dev_req,
    input  logic              legacy_req,
    output logic [DATA_W-1:0] raw_d,
    output logic [DATA_W-1:0] raw_q
);

    typedef struct packed {
        logic [DATA_W-1:0] raw;
    } cap_state_t;

    cap_state_t st_d;
    cap_state_t st_q;

    // Level capture: the register tracks the lines, no latching of edges.
    always_comb begin
        st_d.raw             = dev_req;
        st_d.raw[LEGACY_BIT] = legacy_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_d = st_d.raw;
    assign raw_q = st_q.raw;

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CPU-1:0]             mask_we,
    input  logic [DATA_W-1:0]              mask_wdata,
    input  logic [DATA_W-1:0]              raw_d,
    output logic [NUM_CPU-1:0][DATA_W-1:0] mask_q,
    output logic [NUM_CPU-1:0]             irq_q
);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              irq;
    } lane_t;

    for (genvar n = 0; n < NUM_CPU; n++) begin : g_lane
        lane_t lane_d;
        lane_t lane_q;

        // The output uses next-cycle mask and requests, so a mask write and
        // a request change both land on the output at the same edge.
        always_comb begin
            lane_d      = lane_q;
            if (mask_we[n]) begin
                lane_d.mask = mask_wdata;
            end
            lane_d.irq  = |(lane_d.mask & raw_d);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign mask_q[n] = lane_q.mask;
        assign irq_q[n]  = lane_q.irq;
    end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [DATA_W-1:0]              raw_q,
    input  logic [NUM_CPU-1:0][DATA_W-1:0] mask_q,
    output logic [NUM_CPU-1:0]             mask_we,
    output logic [DATA_W-1:0]              mask_wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic                           err
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } port_state_t;

    port_state_t st_d;
    port_state_t st_q;
    acc_decode_t dec;
    logic [DATA_W-1:0] sel_mask;

    always_comb begin
        dec = decode_ofs(addr, NUM_CPU);
    end

    always_comb begin
        sel_mask = '0;
        for (int n = 0; n < NUM_CPU; n++) begin
            if (dec.cpu == CPU_IDX_W'(n)) begin
                sel_mask = mask_q[n];
            end
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_CPU; n++) begin
            mask_we[n] = wr_en && (dec.kind == ACC_MASK) &&
                         (dec.cpu == CPU_IDX_W'(n));
        end
    end

    assign mask_wdata = wdata;

    always_comb begin
        st_d     = st_q;
        st_d.err = (wr_en || rd_en) && (dec.kind == ACC_BAD);
        if (rd_en) begin
            unique case (dec.kind)
                ACC_RAW:  st_d.rdata = raw_q;
                ACC_MASK: st_d.rdata = sel_mask;
                ACC_VIEW: st_d.rdata = sel_mask & raw_q;
                default:  st_d.rdata = '1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int DATA_W     = 64,
    parameter int LEGACY_BIT = 55
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   dev_req,
    input  logic                legacy_req,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_err,
    output logic [NUM_CPU-1:0]  cpu_irq
);

    logic [DATA_W-1:0]              raw_d;
    logic [DATA_W-1:0]              raw_q;
    logic [NUM_CPU-1:0][DATA_W-1:0] mask_q;
    logic [NUM_CPU-1:0]             mask_we;
    logic [DATA_W-1:0]              mask_wdata;

    irq_raw_capture #(
        .DATA_W     (DATA_W),
        .LEGACY_BIT (LEGACY_BIT)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_req    (dev_req),
        .legacy_req (legacy_req),
        .raw_d      (raw_d),
        .raw_q      (raw_q)
    );

    irq_mask_bank #(
        .NUM_CPU    (NUM_CPU),
        .DATA_W     (DATA_W)
    ) u_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .raw_d      (raw_d),
        .mask_q     (mask_q),
        .irq_q      (cpu_irq)
    );

    irq_reg_port #(
        .NUM_CPU    (NUM_CPU),
        .DATA_W     (DATA_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .raw_q      (raw_q),
        .mask_q     (mask_q),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .rdata      (reg_rdata),
        .err        (reg_err)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [DATA_W-1:0]              dev_req,
    input  logic                           legacy_req,
    input  logic                           reg_wr_en,
    input  logic                           reg_rd_en,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [DATA_W-1:0]              reg_wdata,
    input  logic [DATA_W-1:0]              reg_rdata,
    input  logic                           reg_err,
    input  logic [NUM_CPU-1:0]             cpu_irq,
    input  logic [NUM_CPU-1:0][DATA_W-1:0] mask_q
);

    AST_NO_SOURCE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req == '0 && !legacy_req) |=> (cpu_irq == '0)); // R2

    AST_ZERO_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 12'h200 && reg_wdata == '0) |=> !cpu_irq[0]); // R3

    if (NUM_CPU > 1) begin : g_local
        AST_MASK_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && reg_addr == 12'h200) |=> (mask_q[1] == $past(mask_q[1]))); // R4
    end

    AST_RAW_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_rd_en && reg_addr == 12'h300) |=> !reg_err); // R8

    AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == 12'hFF8) |=> (reg_rdata == '1 && reg_err)); // R9

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en || reg_wr_en) |=> !reg_err); // R11

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata)); // R11

endmodule

bind irq_router irq_router_chk #(
    .NUM_CPU (NUM_CPU),
    .DATA_W  (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_req    (dev_req),
    .legacy_req (legacy_req),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_err    (reg_err),
    .cpu_irq    (cpu_irq),
    .mask_q     (mask_q)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 4;
    localparam int W          = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  dev_req = '0;
    logic          legacy_req = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic          reg_rd_en = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          reg_err;
    logic [NCPU-1:0] cpu_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [W-1:0] exp_mask [NCPU];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_req    (dev_req),
        .legacy_req (legacy_req),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_err    (reg_err),
        .cpu_irq    (cpu_irq)
    );

    function automatic logic [11:0] m_ofs(int n);
        return ((n < 2) ? 12'h200 : 12'h600) + 12'(n % 2) * 12'h040;
    endfunction

    function automatic logic [11:0] v_ofs(int n);
        return m_ofs(n) + 12'h080;
    endfunction

    function automatic logic [W-1:0] exp_raw();
        logic [W-1:0] r;
        r = dev_req;
        r[55] = legacy_req;
        return r;
    endfunction

    function automatic logic [NCPU-1:0] exp_irq();
        logic [NCPU-1:0] v;
        for (int n = 0; n < NCPU; n++) v[n] = |(exp_mask[n] & exp_raw());
        return v;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [W-1:0] d, output logic e);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        e = reg_err;
    endtask

    task automatic rd(logic [11:0] a, output logic [W-1:0] d, output logic e);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
        e = reg_err;
    endtask

    task automatic drive_req(logic [W-1:0] v, logic leg);
        @(negedge clk);
        dev_req = v; legacy_req = leg;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [W-1:0] d; logic e;
        chk("R10 irq", W'(cpu_irq), '0);
        chk("R10 rdata", reg_rdata, '0);
        chk("R10 err", W'(reg_err), '0);
        rd(12'h300, d, e);
        chk("R10 raw", d, '0);
        for (int n = 0; n < NCPU; n++) begin
            rd(m_ofs(n), d, e);
            chk("R10 mask", d, '0);
        end
    endtask

    task automatic t_raw_capture();
        logic [W-1:0] d; logic e;
        drive_req(64'hA5A5_0000_1234_0001, 1'b0);
        rd(12'h300, d, e);
        chk("R7 raw read", d, exp_raw());
        chk("R1 pattern", d, 64'hA5A5_0000_1234_0001 & ~(64'h1 << 55));
        drive_req(64'h1 << 55, 1'b0);
        rd(12'h300, d, e);
        chk("R1 dev bit55 ignored", d, '0);
        drive_req('0, 1'b1);
        rd(12'h300, d, e);
        chk("R1 legacy sets bit55", d, 64'h1 << 55);
        drive_req(64'hFFFF_0000_0000_0000, 1'b0);
        drive_req('0, 1'b0);
        rd(12'h300, d, e);
        chk("R1 lines dropped clear", d, '0);
    endtask

    task automatic t_mask_route();
        logic e;
        drive_req(64'h8, 1'b0);
        chk("R2 no mask no irq", W'(cpu_irq), '0);
        wr(m_ofs(0), 64'h8, e); exp_mask[0] = 64'h8;
        chk("R3 irq at write edge", W'(cpu_irq), W'(4'b0001));
        wr(m_ofs(2), 64'h80, e); exp_mask[2] = 64'h80;
        chk("R3 cpu2 idle", W'(cpu_irq), W'(exp_irq()));
        drive_req(64'h88, 1'b0);
        chk("R2 request raises cpu2", W'(cpu_irq), W'(4'b0101));
        drive_req(64'h80, 1'b0);
        chk("R2 request drop clears cpu0", W'(cpu_irq), W'(4'b0100));
        wr(m_ofs(3), 64'h1 << 55, e); exp_mask[3] = 64'h1 << 55;
        drive_req(64'h0, 1'b1);
        chk("R2 legacy to cpu3", W'(cpu_irq), W'(exp_irq()));
        wr(m_ofs(0), '0, e); exp_mask[0] = '0;
        drive_req(64'h8, 1'b0);
        chk("R3 zeroed mask", W'(cpu_irq), W'(exp_irq()));
    endtask

    task automatic t_isolation();
        logic [W-1:0] d; logic e;
        wr(m_ofs(1), 64'hDEAD_BEEF_0000_0008, e);
        exp_mask[1] = 64'hDEAD_BEEF_0000_0008;
        chk("R4 cpu1 output", W'(cpu_irq), W'(exp_irq()));
        for (int n = 0; n < NCPU; n++) begin
            rd(m_ofs(n), d, e);
            chk("R4 R5 mask readback", d, exp_mask[n]);
        end
    endtask

    task automatic t_view();
        logic [W-1:0] d; logic e;
        drive_req(64'hFFFF_FFFF_0000_00FF, 1'b1);
        for (int n = 0; n < NCPU; n++) begin
            rd(v_ofs(n), d, e);
            chk("R6 masked view", d, exp_mask[n] & exp_raw());
        end
    endtask

    task automatic t_ro_writes();
        logic [W-1:0] d; logic e;
        wr(12'h300, '1, e);
        chk("R8 raw write no err", W'(e), '0);
        rd(12'h300, d, e);
        chk("R8 raw unchanged", d, exp_raw());
        wr(v_ofs(1), '1, e);
        chk("R8 view write no err", W'(e), '0);
        rd(v_ofs(1), d, e);
        chk("R8 view unchanged", d, exp_mask[1] & exp_raw());
        chk("R8 outputs unchanged", W'(cpu_irq), W'(exp_irq()));
    endtask

    task automatic t_unassigned();
        logic [W-1:0] d; logic e;
        rd(12'hFF8, d, e);
        chk("R9 read ones", d, '1);
        chk("R9 read err", W'(e), 1);
        rd(12'h204, d, e);
        chk("R9 misaligned ones", d, '1);
        rd(12'h008, d, e);
        chk("R9 low offset err", W'(e), 1);
        wr(12'h100, 64'h1234, e);
        chk("R9 write err", W'(e), 1);
        @(negedge clk);
        chk("R11 err one cycle", W'(reg_err), '0);
        for (int n = 0; n < NCPU; n++) begin
            rd(m_ofs(n), d, e);
            chk("R9 masks untouched", d, exp_mask[n]);
        end
    endtask

    task automatic t_hold();
        logic [W-1:0] d; logic e;
        rd(12'h300, d, e);
        drive_req(64'h5555, 1'b0);
        @(negedge clk);
        chk("R11 rdata held", reg_rdata, d);
        rd(12'h300, d, e);
        chk("R11 new read", d, exp_raw());
    endtask

    initial begin
        for (int n = 0; n < NCPU; n++) exp_mask[n] = '0;
        repeat (3) @(negedge clk);
        chk("R10 in reset irq", W'(cpu_irq), '0);
        rst_n = 1'b1;
        t_reset();
        t_raw_capture();
        t_mask_route();
        t_isolation();
        t_view();
        t_ro_writes();
        t_unassigned();
        t_hold();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule